// File: doc/BRIEF.md
# Serial Port Register Block with Watermark Interrupts

This block is the software-facing register set of a simple serial port. A processor reaches it through a 32-bit, word-only request/response bus slave. Incoming bytes from a deserializer enter through a valid/ready byte stream and are queued in a small receive FIFO. Software pops the FIFO by reading the receive-data register. A receive-data read on an empty FIFO does not stall: it returns a word with bit 31 set to mark it as empty.

A write to the transmit-data register emits its low byte on a transmit byte stream as a one-cycle strobe. The transmit side is modelled as always drained. The block also holds transmit-control, receive-control, interrupt-enable and divisor registers. The divisor drives a port that serializer timing logic reads.

Two pending flags are derived from watermark counts in bits 18:16 of the control registers. A single registered, level-sensitive interrupt line is formed from the enables and the FIFO state.

Top module: `serial_port_regs`

## Requirements
- R1: Only requests with bus_size equal to 2 (four bytes) and bus_addr[1:0] equal to 0 are legal. Every request gets bus_ack in the next cycle. An illegal request also raises bus_err in that cycle, returns 0 and changes no state.
- R2: A read of the receive-data register at offset 0x04 on a non-empty FIFO returns the oldest byte in bits 7:0, with bits 31:8 zero, and removes that byte.
- R3: A read of offset 0x04 on an empty FIFO returns 0x80000000 and leaves the FIFO empty.
- R4: A write to offset 0x00 produces tx_valid high for exactly the next cycle, with tx_data equal to bits 7:0 of the written word. A read of offset 0x00 returns 0.
- R5: Bit 0 of the pending register (offset 0x14) is 1 exactly when bits 18:16 of the transmit-control register (offset 0x08) are nonzero.
- R6: Bit 1 of the pending register is 1 exactly when the FIFO occupancy is strictly greater than bits 18:16 of the receive-control register (offset 0x0C). Bits 31:2 of the pending register read 0.
- R7: irq is a register. It is high when interrupt-enable bit 0 is set, or when interrupt-enable bit 1 is set and the FIFO is non-empty; otherwise it is low. It follows a push, a pop or an enable write one cycle after the state changes.
- R8: The transmit-control, receive-control, interrupt-enable (offset 0x10) and divisor (offset 0x18) registers read back all 32 bits last written. All four reset to 0. The divisor is driven on baud_div.
- R9: rx_ready is high only while the FIFO holds fewer than FIFO_DEPTH bytes. A byte presented while the FIFO is full is not stored.
- R10: A legal access to an offset with no register raises bus_err and returns 0. A write to such an offset changes no register.
- R11: A write to the pending register is accepted without error and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Request strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 2 | log2 of the access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Response strobe, one cycle after the request |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_err | output | 1 | Access error, valid with bus_ack |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | FIFO can take a byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| baud_div | output | 32 | Divisor register contents |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: an eight-entry FIFO and a three-bit watermark field. With these values a full FIFO takes only a few pushes, so the drop-on-full and refill paths are exercised many times. Every watermark level from 0 to 7 can be set against every occupancy from 0 to 8, which reaches both sides of the strictly-greater-than comparison, including the case where the flag can only set at a completely full FIFO.

// File: rtl/serial_port_regs_pkg.sv
package serial_port_regs_pkg;
  localparam int unsigned OFS_TXD  = 32'h00;
  localparam int unsigned OFS_RXD  = 32'h04;
  localparam int unsigned OFS_TXC  = 32'h08;
  localparam int unsigned OFS_RXC  = 32'h0C;
  localparam int unsigned OFS_IEN  = 32'h10;
  localparam int unsigned OFS_PEND = 32'h14;
  localparam int unsigned OFS_DIV  = 32'h18;
  localparam logic [31:0] RX_EMPTY_WORD = 32'h8000_0000;
  localparam int unsigned IRQ_TX_BIT = 0;
  localparam int unsigned IRQ_RX_BIT = 1;
endpackage

// File: rtl/spr_rx_fifo.sv
module spr_rx_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    din,
  input  logic             pop,
  output logic [DW-1:0]    head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign full  = (32'(count) == DEPTH);
  assign empty = (count == '0);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spr_pending.sv
module spr_pending #(
  parameter int unsigned WM_W  = 3,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WM_W-1:0]  tx_level,
  input  logic [WM_W-1:0]  rx_level,
  input  logic [1:0]       enables,
  input  logic [CNT_W-1:0] occupancy,
  output logic [1:0]       pending,
  output logic             irq_q
);
  function automatic logic tx_flag(input logic [WM_W-1:0] lvl);
    return lvl != '0;
  endfunction

  function automatic logic rx_flag(input logic [CNT_W-1:0] occ, input logic [WM_W-1:0] lvl);
    return 32'(occ) > 32'(lvl);
  endfunction

  function automatic logic irq_level(input logic [1:0] en, input logic [CNT_W-1:0] occ);
    return en[0] | (en[1] & (occ != '0));
  endfunction

  assign pending = {rx_flag(occupancy, rx_level), tx_flag(tx_level)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_level(enables, occupancy);
  end
endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import serial_port_regs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned WM_LSB     = 16,
  parameter int unsigned WM_W       = 3,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ack,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic [31:0]       baud_div,
  output logic              irq
);
  logic [31:0] txctl_q, rxctl_q, ien_q, div_q;
  logic        legal, hit_txd, hit_rxd, hit_txc, hit_rxc, hit_ien, hit_pend, hit_div;
  logic        acc_err, fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [7:0]  fifo_head;
  logic [CNT_W-1:0] fifo_count;
  logic [1:0]  pend;
  logic [31:0] rd_mux;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign legal    = bus_req && (bus_size == 2'd2) && (bus_addr[1:0] == 2'b00);
  assign hit_txd  = legal && hit(bus_addr, OFS_TXD);
  assign hit_rxd  = legal && hit(bus_addr, OFS_RXD);
  assign hit_txc  = legal && hit(bus_addr, OFS_TXC);
  assign hit_rxc  = legal && hit(bus_addr, OFS_RXC);
  assign hit_ien  = legal && hit(bus_addr, OFS_IEN);
  assign hit_pend = legal && hit(bus_addr, OFS_PEND);
  assign hit_div  = legal && hit(bus_addr, OFS_DIV);
  assign acc_err  = bus_req && !(hit_txd || hit_rxd || hit_txc || hit_rxc ||
                                 hit_ien || hit_pend || hit_div);

  assign rx_ready  = !fifo_full;
  assign fifo_push = rx_valid && rx_ready;
  assign fifo_pop  = hit_rxd && !bus_we && !fifo_empty;

  spr_rx_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .din(rx_data), .pop(fifo_pop),
    .head(fifo_head), .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  spr_pending #(.WM_W(WM_W), .CNT_W(CNT_W)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .tx_level(txctl_q[WM_LSB +: WM_W]), .rx_level(rxctl_q[WM_LSB +: WM_W]),
    .enables({ien_q[IRQ_RX_BIT], ien_q[IRQ_TX_BIT]}), .occupancy(fifo_count),
    .pending(pend), .irq_q(irq)
  );

  always_comb begin
    rd_mux = '0;
    if (!bus_we) begin
      if (hit_rxd)       rd_mux = fifo_empty ? RX_EMPTY_WORD : {24'd0, fifo_head};
      else if (hit_txc)  rd_mux = txctl_q;
      else if (hit_rxc)  rd_mux = rxctl_q;
      else if (hit_ien)  rd_mux = ien_q;
      else if (hit_pend) rd_mux = {30'd0, pend};
      else if (hit_div)  rd_mux = div_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txctl_q <= '0; rxctl_q <= '0; ien_q <= '0; div_q <= '0;
      bus_ack <= 1'b0; bus_err <= 1'b0; bus_rdata <= '0;
      tx_valid <= 1'b0; tx_data <= '0;
    end else begin
      if (hit_txc && bus_we) txctl_q <= bus_wdata;
      if (hit_rxc && bus_we) rxctl_q <= bus_wdata;
      if (hit_ien && bus_we) ien_q   <= bus_wdata;
      if (hit_div && bus_we) div_q   <= bus_wdata;
      bus_ack   <= bus_req;
      bus_err   <= acc_err;
      bus_rdata <= rd_mux;
      tx_valid  <= hit_txd && bus_we;
      if (hit_txd && bus_we) tx_data <= bus_wdata[7:0];
    end
  end

  assign baud_div = div_q;
endmodule

// File: rtl/serial_port_regs_chk.sv
module serial_port_regs_chk #(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned CNT_W      = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic              bus_ack,
  input logic              bus_err,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              irq,
  input logic [CNT_W-1:0]  fifo_count,
  input logic [1:0]        ien_lo
);
  logic rxd_read, txd_write;
  assign rxd_read  = bus_req && !bus_we && bus_size == 2'd2 && bus_addr == ADDR_W'(4);
  assign txd_write = bus_req && bus_we && bus_size == 2'd2 && bus_addr == ADDR_W'(0);

  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) bus_req |=> bus_ack); // R1
  AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n) bus_err |-> bus_ack); // R1
  AST_EMPTY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd_read && fifo_count == '0 && !(rx_valid && rx_ready)) |=> fifo_count == '0); // R3
  AST_TX_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(txd_write)); // R4
  AST_IRQ_TX_EN: assert property (@(posedge clk) disable iff (!rst_n) ien_lo[0] |=> irq); // R7
  AST_IRQ_NONE_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_lo == 2'b00) |=> !irq); // R7
  AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fifo_count) == FIFO_DEPTH) |-> !rx_ready); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fifo_count) <= FIFO_DEPTH); // R9
endmodule

bind serial_port_regs serial_port_regs_chk #(
  .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_size(bus_size), .bus_ack(bus_ack), .bus_err(bus_err), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .irq(irq), .fifo_count(fifo_count),
  .ien_lo(ien_q[1:0])
);

// File: tb/serial_port_regs_tb.sv
module serial_port_regs_tb;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 0, bus_we = 0;
  logic [5:0] bus_addr = '0;
  logic [1:0] bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ack, bus_err, rx_ready, tx_valid, irq;
  logic [31:0] bus_rdata, baud_div;
  logic rx_valid = 0;
  logic [7:0] rx_data = '0, tx_data;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0]  mq[$];
  logic [31:0] m_txc = 0, m_rxc = 0, m_ien = 0, m_div = 0;

  serial_port_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .baud_div(baud_div), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pend();
    logic [31:0] r = 0;
    r[0] = m_txc[18:16] != 3'd0;
    r[1] = mq.size() > int'(m_rxc[18:16]);
    return r;
  endfunction

  function automatic logic exp_irq();
    return m_ien[0] | (m_ien[1] & (mq.size() != 0));
  endfunction

  task automatic bus(input bit we, input logic [5:0] a, input logic [1:0] sz, input logic [31:0] wd,
                     output logic [31:0] rd, output logic er, output logic txv, output logic [7:0] txd);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
    chk(bus_ack === 1'b1, "R1 ack", {31'd0, bus_ack}, 32'd1);
    rd = bus_rdata; er = bus_err; txv = tx_valid; txd = tx_data;
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] wd);
    logic [31:0] rd; logic er, tv; logic [7:0] td;
    bus(1, a, 2'd2, wd, rd, er, tv, td);
    chk(er === 1'b0, "R8 write no error", {31'd0, er}, 0);
    case (a)
      6'h08: m_txc = wd;
      6'h0C: m_rxc = wd;
      6'h10: m_ien = wd;
      6'h18: m_div = wd;
      default: ;
    endcase
  endtask

  task automatic reg_read(input logic [5:0] a, input logic [31:0] exp, input string req);
    logic [31:0] rd; logic er, tv; logic [7:0] td;
    bus(0, a, 2'd2, 0, rd, er, tv, td);
    chk(rd === exp && er === 1'b0, req, rd, exp);
  endtask

  task automatic pop_check();
    logic [31:0] exp;
    if (mq.size() == 0) exp = 32'h8000_0000;
    else exp = {24'd0, mq.pop_front()};
    reg_read(6'h04, exp, (exp == 32'h8000_0000) ? "R3 empty read" : "R2 pop oldest");
  endtask

  task automatic push(input logic [7:0] b);
    logic rdy;
    @(negedge clk);
    rdy = rx_ready;
    chk(rdy === (mq.size() < DEPTH), "R9 ready", {31'd0, rdy}, {31'd0, mq.size() < DEPTH});
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
    if (mq.size() < DEPTH) mq.push_back(b);
  endtask

  task automatic irq_check();
    @(negedge clk);
    chk(irq === exp_irq(), "R7 irq level", {31'd0, irq}, {31'd0, exp_irq()});
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=0x%08h expected=0x%08h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd; logic er, tv; logic [7:0] td;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(irq === 1'b0 && rx_ready === 1'b1 && baud_div === 0, "R8 reset", {irq, rx_ready, baud_div[29:0]}, 32'h4000_0000);
    reg_read(6'h08, 0, "R8 txctl reset");
    reg_read(6'h10, 0, "R8 ien reset");
    reg_read(6'h14, 0, "R5 pend reset");
    pop_check();

    // R4 transmit
    bus(1, 6'h00, 2'd2, 32'hABCD_12A5, rd, er, tv, td);
    chk(tv === 1'b1 && td === 8'hA5 && er === 1'b0, "R4 tx strobe", {23'd0, tv, td}, 32'h1A5);
    @(negedge clk);
    chk(tx_valid === 1'b0, "R4 tx one cycle", {31'd0, tx_valid}, 0);
    reg_read(6'h00, 0, "R4 txd reads 0");

    // R8 readback and divisor port
    reg_write(6'h18, 32'hDEAD_BEEF);
    reg_read(6'h18, 32'hDEAD_BEEF, "R8 div readback");
    chk(baud_div === 32'hDEAD_BEEF, "R8 baud_div port", baud_div, 32'hDEAD_BEEF);

    // R1 illegal accesses
    bus(1, 6'h19, 2'd2, 32'h1, rd, er, tv, td);
    chk(er === 1'b1 && rd === 0, "R1 misaligned err", {31'd0, er}, 1);
    bus(1, 6'h18, 2'd1, 32'h2, rd, er, tv, td);
    chk(er === 1'b1, "R1 bad size err", {31'd0, er}, 1);
    bus(0, 6'h06, 2'd2, 0, rd, er, tv, td);
    chk(er === 1'b1 && rd === 0, "R1 misaligned read", rd, 0);
    reg_read(6'h18, 32'hDEAD_BEEF, "R1 div unchanged");

    // R10 unmapped
    bus(0, 6'h1C, 2'd2, 0, rd, er, tv, td);
    chk(er === 1'b1 && rd === 0, "R10 unmapped read", rd, 0);
    bus(1, 6'h3C, 2'd2, 32'hFFFF_FFFF, rd, er, tv, td);
    chk(er === 1'b1 && tv === 1'b0, "R10 unmapped write", {31'd0, er}, 1);
    reg_read(6'h18, 32'hDEAD_BEEF, "R10 no change");

    // R11 pending write ignored
    bus(1, 6'h14, 2'd2, 32'h3, rd, er, tv, td);
    chk(er === 1'b0, "R11 no error", {31'd0, er}, 0);
    reg_read(6'h14, exp_pend(), "R11 pend unchanged");

    // R7 timing: rx enable, push, irq one cycle after state change
    reg_write(6'h10, 32'h2);
    irq_check();
    @(negedge clk);
    rx_valid = 1; rx_data = 8'h3C;
    @(negedge clk);
    rx_valid = 0; mq.push_back(8'h3C);
    chk(irq === 1'b0, "R7 irq not yet", {31'd0, irq}, 0);
    @(negedge clk);
    chk(irq === 1'b1, "R7 irq next cycle", {31'd0, irq}, 1);

    // R9 fill to full, drop, drain
    for (int i = 0; i < DEPTH + 2; i++) push(8'(8'h40 + i));
    chk(rx_ready === 1'b0, "R9 full not ready", {31'd0, rx_ready}, 0);
    reg_write(6'h0C, 32'h0007_0000);
    reg_read(6'h14, exp_pend(), "R6 full over wm 7");
    for (int i = 0; i < DEPTH + 1; i++) pop_check();
    irq_check();

    // R5/R6 watermark sweep
    for (int lvl = 0; lvl < 8; lvl++) begin
      reg_write(6'h08, {13'd0, 3'(lvl), 16'h1234});
      reg_write(6'h0C, {13'd0, 3'(lvl), 16'h0});
      reg_read(6'h14, exp_pend(), "R5 R6 pend sweep");
      push(8'(lvl));
      reg_read(6'h14, exp_pend(), "R6 pend after push");
    end

    // random mix
    for (int n = 0; n < 600; n++) begin
      int unsigned op = $urandom_range(0, 9);
      case (op)
        0, 1, 2: push(8'($urandom));
        3, 4:    pop_check();
        5:       reg_write(6'h08, $urandom);
        6:       reg_write(6'h0C, $urandom);
        7:       reg_write(6'h10, $urandom);
        8:       reg_read(6'h14, exp_pend(), "R5 R6 random pend");
        default: begin
          reg_read(6'h08, m_txc, "R8 random txctl");
          reg_read(6'h0C, m_rxc, "R8 random rxctl");
          reg_read(6'h10, m_ien, "R8 random ien");
        end
      endcase
      irq_check();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule